// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a free-running timer counter. It holds a single register, `CNT_W` bits wide, which works in one of two modes chosen by a mode bit. In compare mode, software loads the register. On each counting cycle the channel compares the register with the counter and raises a one-cycle interrupt pulse when they are equal. In capture mode, the register ignores software writes. A selected transition on the external timer pin copies the current counter value into the register and pulses the interrupt.

A compare value of zero gets special treatment. The counter starts at zero, so an unconditional compare would fire as soon as counting begins. Instead, a zero compare value only fires after the counter has wrapped or been cleared. The counter, its prescaler, the pin synchronizer and the bus decoding all sit outside this block. The block takes the counter value and its event strobes as inputs. It expects the pin to be already synchronized to `clk`.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: After reset, the stored value reads 0x0000 and `irq` is low.
- R2: In compare mode (`capMode`=0), `wrEn` loads `wrData`. The new value is visible on `rdData` after the next clock edge, and it can be rewritten at any time while the counter runs.
- R3: In compare mode, when `cntTick` is high and `cntVal` equals a nonzero stored value, `irq` is high for the cycle after that edge. Equality without `cntTick` raises nothing.
- R4: With a stored value of 0x0000, equality with a zero counter raises `irq` only if a `cntOvf` or `cntClr` strobe has occurred since reset or since the last zero match. A zero match consumes that permission.
- R5: In capture mode with `edgeSel`=01, a 0-to-1 transition of `pinSync` copies `cntVal` into the register and pulses `irq`. A 1-to-0 transition does nothing.
- R6: With `edgeSel`=00, only a 1-to-0 transition of `pinSync` captures.
- R7: With `edgeSel`=11, both transitions capture.
- R8: `edgeSel`=10 is a reserved code. No transition captures, and the register and `irq` stay unchanged.
- R9: A valid edge that arrives together with `cntStop` leaves the register unchanged and raises no `irq`.
- R10: `rdData` reads the register combinationally. In the cycle of a capture it still shows the previous value, and the captured value appears after the edge.
- R11: In capture mode, `wrEn` has no effect on the register.
- R12: `irq` is a single-cycle pulse per event. It drops in the cycle after an event unless a new event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capMode | input | 1 | 0 = compare, 1 = capture |
| edgeSel | input | 2 | Capture edge code: 00 fall, 01 rise, 11 both, 10 reserved |
| wrEn | input | 1 | Software write strobe |
| wrData | input | CNT_W | Software write data |
| rdData | output | CNT_W | Current register value |
| cntVal | input | CNT_W | Counter value |
| cntTick | input | 1 | Counter counts this cycle |
| cntOvf | input | 1 | Counter wraps this cycle |
| cntClr | input | 1 | Counter is cleared this cycle (match, pin or one-shot) |
| cntStop | input | 1 | Counter stop request this cycle |
| pinSync | input | 1 | Synchronized external timer pin |
| irq | output | 1 | Interrupt pulse |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a capture and a software read. The bench raises a valid pin transition and samples `rdData` before the capturing edge, then checks the old value there and the counter value one cycle later.

The second pair is a capture and a counter stop. The bench presents the edge together with `cntStop` and expects no load and no pulse.

A further case combines a compare wrap with the zero value. A wrap strobe is placed ahead of a zero count, and the bench judges whether the pulse appears exactly once.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_RSVD = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic loadWr;
    logic loadCap;
    logic irqSet;
  } chan_stb_t;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      capMode,
  input  logic [1:0] edgeSel,
  input  logic      pinSync,
  input  logic      cntTick,
  input  logic      cntOvf,
  input  logic      cntClr,
  input  logic      cntStop,
  input  logic      wrEn,
  input  logic      eqHit,
  input  logic      valIsZero,
  output chan_stb_t stb,
  output logic      irq
);
  logic pinPrev;
  logic zeroArmed;
  logic riseSeen, fallSeen, edgeValid;
  logic cmpHit, capHit;

  assign riseSeen = pinSync & ~pinPrev;
  assign fallSeen = ~pinSync & pinPrev;

  always_comb begin
    unique case (edge_sel_e'(edgeSel))
      EDGE_FALL: edgeValid = fallSeen;
      EDGE_RISE: edgeValid = riseSeen;
      EDGE_BOTH: edgeValid = riseSeen | fallSeen;
      default:   edgeValid = 1'b0;
    endcase
  end

  assign cmpHit = ~capMode & cntTick & eqHit & (~valIsZero | zeroArmed);
  assign capHit = capMode & edgeValid & ~cntStop;

  always_comb begin
    stb.loadWr  = ~capMode & wrEn;
    stb.loadCap = capHit;
    stb.irqSet  = cmpHit | capHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev   <= 1'b0;
      zeroArmed <= 1'b0;
      irq       <= 1'b0;
    end else begin
      pinPrev <= pinSync;
      irq     <= stb.irqSet;
      if (cntOvf || cntClr)
        zeroArmed <= 1'b1;
      else if (cmpHit && valIsZero)
        zeroArmed <= 1'b0;
    end
  end

  // R3: a compare pulse needs a counting cycle behind it
  p_irq_needs_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(capMode) || $past(cntTick)));

  // R8: reserved code never starts a capture
  p_rsvd_no_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capMode && edgeSel == 2'b10) |-> !stb.loadCap);
endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chan_stb_t        stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] value,
  output logic             eqHit,
  output logic             valIsZero
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (!rstN)
      value <= ZERO;
    else if (stb.loadCap)
      value <= cntVal;
    else if (stb.loadWr)
      value <= wrData;
  end

  assign eqHit     = (value == cntVal);
  assign valIsZero = (value == ZERO);

  // R5: a capture strobe lands the counter value in the register
  p_cap_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCap |=> value == $past(cntVal));

  // R2: a compare-mode write lands in the register
  p_cmp_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadWr && !stb.loadCap) |=> value == $past(wrData));
endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capMode,
  input  logic [1:0]       edgeSel,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntTick,
  input  logic             cntOvf,
  input  logic             cntClr,
  input  logic             cntStop,
  input  logic             pinSync,
  output logic             irq
);
  chan_stb_t stb;
  logic eqHit, valIsZero;

  tcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .capMode(capMode), .edgeSel(edgeSel),
    .pinSync(pinSync), .cntTick(cntTick), .cntOvf(cntOvf), .cntClr(cntClr),
    .cntStop(cntStop), .wrEn(wrEn), .eqHit(eqHit), .valIsZero(valIsZero),
    .stb(stb), .irq(irq)
  );

  tcc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .cntVal(cntVal),
    .value(rdData), .eqHit(eqHit), .valIsZero(valIsZero)
  );

  // R9: a stop request in capture mode freezes the register
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capMode && cntStop) |=> $stable(rdData));

  // R11: writes are ignored in capture mode when no pin transition occurs
  p_cap_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (capMode && wrEn && $stable(pinSync)) |=> $stable(rdData));
endmodule

// File: tb/tmr_capcmp_chan_tb.sv
module tmr_capcmp_chan_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capMode = 1'b0;
  logic [1:0] edgeSel = 2'b01;
  logic wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic [W-1:0] cntVal = '0;
  logic cntTick = 1'b0, cntOvf = 1'b0, cntClr = 1'b0, cntStop = 1'b0;
  logic pinSync = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic         eIrq;
    logic [W-1:0] eRd;
    string        tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  tmr_capcmp_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .capMode(capMode), .edgeSel(edgeSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .cntVal(cntVal),
    .cntTick(cntTick), .cntOvf(cntOvf), .cntClr(cntClr), .cntStop(cntStop),
    .pinSync(pinSync), .irq(irq)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: inputs already set at a negedge; queue the result due after the next edge
  task automatic step(input logic eIrq, input logic [W-1:0] eRd, input string tag);
    exp_t e;
    e.eIrq = eIrq; e.eRd = eRd; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    wrEn = 1'b0; cntTick = 1'b0; cntOvf = 1'b0; cntClr = 1'b0; cntStop = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, e.eIrq});
        check({e.tag, " rdData"}, rdData, e.eRd);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset value", rdData, 16'h0000);
    check("R1 reset irq", {15'd0, irq}, 16'd0);

    // compare mode
    wrEn = 1; wrData = 16'h0005;           step(0, 16'h0005, "R2 write");
    cntVal = 16'h0005;                      step(0, 16'h0005, "R3 no tick");
    cntTick = 1;                            step(1, 16'h0005, "R3 match");
    cntTick = 1; cntVal = 16'h0006;         step(0, 16'h0005, "R12 pulse drop");
    wrEn = 1; wrData = 16'h0006; cntTick = 1; cntVal = 16'h0007;
                                            step(0, 16'h0006, "R2 rewrite running");
    // zero compare
    wrEn = 1; wrData = 16'h0000;           step(0, 16'h0000, "R2 write zero");
    cntTick = 1; cntVal = 16'h0000;         step(0, 16'h0000, "R4 not armed");
    cntTick = 1; cntOvf = 1; cntVal = 16'hFFFF; step(0, 16'h0000, "R4 overflow");
    cntTick = 1; cntVal = 16'h0000;         step(1, 16'h0000, "R4 after overflow");
    cntTick = 1; cntVal = 16'h0000;         step(0, 16'h0000, "R4 consumed");
    cntClr = 1; cntVal = 16'h0003;          step(0, 16'h0000, "R4 clear");
    cntTick = 1; cntVal = 16'h0000;         step(1, 16'h0000, "R4 after clear");

    // capture mode, rising
    capMode = 1; edgeSel = 2'b01; pinSync = 0; step(0, 16'h0000, "R5 idle");
    cntVal = 16'h1234; pinSync = 1;
    #1 check("R10 read during capture", rdData, 16'h0000);
                                            step(1, 16'h1234, "R5 rise capture");
    cntVal = 16'h2000; pinSync = 0;         step(0, 16'h1234, "R5 fall ignored");
    // falling
    edgeSel = 2'b00; cntVal = 16'h3000; pinSync = 1; step(0, 16'h1234, "R6 rise ignored");
    cntVal = 16'h3111; pinSync = 0;         step(1, 16'h3111, "R6 fall capture");
    // both
    edgeSel = 2'b11; cntVal = 16'h4000; pinSync = 1; step(1, 16'h4000, "R7 rise capture");
    cntVal = 16'h4001; pinSync = 0;         step(1, 16'h4001, "R7 fall capture");
    // reserved
    edgeSel = 2'b10; cntVal = 16'h5000; pinSync = 1; step(0, 16'h4001, "R8 rise none");
    cntVal = 16'h5001; pinSync = 0;         step(0, 16'h4001, "R8 fall none");
    // stop coincident
    edgeSel = 2'b01; cntVal = 16'h6000; pinSync = 1; cntStop = 1;
                                            step(0, 16'h4001, "R9 stop blocks");
    pinSync = 0;                            step(0, 16'h4001, "R9 idle");
    // write in capture mode
    wrEn = 1; wrData = 16'hBEEF;            step(0, 16'h4001, "R11 write ignored");
    step(0, 16'h4001, "R11 hold");

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule